// File: doc/BRIEF.md
# Serial DAC Word Loader

This block sits on the host side of a double-buffered serial digital-to-analog converter. A requester presents a 12-bit code together with a one-cycle start strobe. The loader captures the code and shifts it out on a serial data line and a serial clock line, most significant bit first. It then drives a separate active-low load line low for a short pulse, and that pulse moves the shifted word into the converter's output register. No chip select frames the transfer. The load pulse alone commits the word, and it follows exactly twelve rising clock edges.

Every serial phase has its own length in system clock cycles: data setup before the rising edge, clock high, clock low with data still held, and load low. Each length is worked out from a nanosecond minimum and the system clock frequency, and it is rounded up. A bipolar input flips the top bit of the captured code, which turns a two's-complement value into offset binary. A busy flag and a one-cycle done pulse form the handshake back to the requester.

Top module: `dacWordLoader`

## Requirements
- R1: The 12 bits are sent most significant bit first. The data line changes only while the serial clock is low, so a receiver that samples on each rising edge assembles exactly the captured code.
- R2: Exactly 12 rising serial clock edges occur between acceptance and the falling edge of the load line. The load line never falls before the twelfth rising edge.
- R3: The load line stays high except for one low pulse per transfer. That pulse lasts LOAD cycles (6 at 50 MHz, at least 120 ns), and the serial clock is low throughout it.
- R4: The data line is stable for at least 40 ns (2 cycles at 50 MHz) before every rising serial clock edge.
- R5: Data is held for at least 80 ns after each rising edge. The clock stays high for at least 90 ns (5 cycles) and low for at least 120 ns (6 cycles).
- R6: When bipolar is 1 at acceptance, bit 11 of the code is inverted before shifting and bits 10..0 pass unchanged. When bipolar is 0, the code passes unchanged.
- R7: A start is accepted only while busy is 0, and the code is captured in the accepting cycle. A start while busy is ignored: it changes neither the word in flight nor the edge count.
- R8: Busy rises one cycle after acceptance and stays high for 12*(2+5+6)+6 = 162 cycles at the default settings. Busy falls on the edge where the load line returns high, and done is high for exactly that one following cycle.
- R9: A synchronous active-high reset sets busy 0, done 0, serial clock 0, data 0 and the load line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request, sampled while idle |
| code | input | 12 | Code to send |
| bipolar | input | 1 | Invert the top bit of the code (two's complement to offset binary) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the load line returns high |
| sclk | output | 1 | Serial clock to the converter |
| sdata | output | 1 | Serial data to the converter |
| ldN | output | 1 | Active-low load strobe to the converter |

## Verification
Busy is due at the first sampling point after the accepting edge. The bench then counts busy cycles at falling clock edges until busy drops, expects 162, and requires done in exactly that cycle. The timing minimums are measured in nanoseconds, from the moment each serial line toggles in the receiver model. The received word is compared with the expected code only once the load line has risen, which is the instant the converter would commit it. A second start issued mid-transfer tests that the received word and the edge count are unaffected.

// File: rtl/dacLoaderPkg.sv
package dacLoaderPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_LOAD
  } loaderStateT;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capture;
    logic shift;
    logic clkRise;
    logic clkFall;
    logic ldAssert;
    logic ldRelease;
  } loaderStbT;

  // cycles needed to cover a minimum in ns at a clock in MHz, rounded up
  function automatic int cyclesFor(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacLoaderCtrl.sv
module dacLoaderCtrl
  import dacLoaderPkg::*;
#(
  parameter int WORD_BITS = 12,
  parameter int SETUP_LEN = 2,
  parameter int HIGH_LEN  = 5,
  parameter int LOW_LEN   = 6,
  parameter int LOAD_LEN  = 6,
  parameter int CNT_W     = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output loaderStbT stb,
  output logic      busy,
  output logic      done
);

  localparam int BIT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_LEN - 1);
  localparam logic [CNT_W-1:0] HIGH_M1  = CNT_W'(HIGH_LEN - 1);
  localparam logic [CNT_W-1:0] LOW_M1   = CNT_W'(LOW_LEN - 1);
  localparam logic [CNT_W-1:0] LOAD_M1  = CNT_W'(LOAD_LEN - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  loaderStateT      state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             phaseEnd;

  assign phaseEnd = (phaseCnt == '0);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE:  stb.capture   = start;
      ST_SETUP: stb.clkRise   = phaseEnd;
      ST_HIGH:  stb.clkFall   = phaseEnd;
      ST_LOW: begin
        stb.ldAssert = phaseEnd && (bitIdx == LAST_BIT);
        stb.shift    = phaseEnd && (bitIdx != LAST_BIT);
      end
      ST_LOAD:  stb.ldRelease = phaseEnd;
      default:  stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SETUP;
          phaseCnt <= SETUP_M1;
          bitIdx   <= '0;
          busy     <= 1'b1;
        end
        ST_SETUP: if (phaseEnd) begin
          state    <= ST_HIGH;
          phaseCnt <= HIGH_M1;
        end
        ST_HIGH: if (phaseEnd) begin
          state    <= ST_LOW;
          phaseCnt <= LOW_M1;
        end
        ST_LOW: if (phaseEnd) begin
          if (bitIdx == LAST_BIT) begin
            state    <= ST_LOAD;
            phaseCnt <= LOAD_M1;
          end else begin
            state    <= ST_SETUP;
            phaseCnt <= SETUP_M1;
            bitIdx   <= bitIdx + 1'b1;
          end
        end
        ST_LOAD: if (phaseEnd) begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // a start while busy must not restart capture (R7)
  p_no_capture_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !stb.capture);

  // the load pulse is only raised once the last bit slot has ended (R2)
  p_load_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    stb.ldAssert |=> (state == ST_LOAD));

endmodule

// File: rtl/dacLoaderPath.sv
module dacLoaderPath
  import dacLoaderPkg::*;
#(
  parameter int WORD_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  loaderStbT            stb,
  input  logic [WORD_BITS-1:0] code,
  input  logic                 bipolar,
  output logic                 sclk,
  output logic                 sdata,
  output logic                 ldN
);

  localparam int TOP = WORD_BITS - 1;

  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] mapped;

  generate
    if (WORD_BITS > 1) begin : g_map
      assign mapped = {code[TOP] ^ bipolar, code[TOP-1:0]};
    end else begin : g_map1
      assign mapped = code ^ bipolar;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      sclk     <= 1'b0;
      ldN      <= 1'b1;
    end else begin
      if (stb.capture)   shiftReg <= mapped;
      if (stb.shift)     shiftReg <= shiftReg << 1;
      if (stb.ldRelease) shiftReg <= '0;
      if (stb.clkRise)   sclk <= 1'b1;
      if (stb.clkFall)   sclk <= 1'b0;
      if (stb.ldAssert)  ldN  <= 1'b0;
      if (stb.ldRelease) ldN  <= 1'b1;
    end
  end

  assign sdata = shiftReg[TOP];

  // data frozen across the rising edge and while the clock is high (R4, R5)
  p_data_steady_high_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdata));

  // clock held low while the load line is low (R3)
  p_clk_low_in_load_r3: assert property (@(posedge clk) disable iff (rst)
    !ldN |-> !sclk);

endmodule

// File: rtl/dacWordLoader.sv
module dacWordLoader
  import dacLoaderPkg::*;
#(
  parameter int WORD_BITS   = 12,
  parameter int SYS_MHZ     = 50,
  parameter int SETUP_MINNS = 40,
  parameter int HOLD_MINNS  = 80,
  parameter int HIGH_MINNS  = 90,
  parameter int LOW_MINNS   = 120,
  parameter int LOAD_MINNS  = 120
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [WORD_BITS-1:0] code,
  input  logic                 bipolar,
  output logic                 busy,
  output logic                 done,
  output logic                 sclk,
  output logic                 sdata,
  output logic                 ldN
);

  localparam int SETUP_LEN = cyclesFor(SETUP_MINNS, SYS_MHZ);
  localparam int HIGH_LEN  = cyclesFor(HIGH_MINNS, SYS_MHZ);
  localparam int HOLD_LEN  = cyclesFor(HOLD_MINNS, SYS_MHZ);
  localparam int LOW_LEN   = maxOf(cyclesFor(LOW_MINNS, SYS_MHZ), HOLD_LEN - HIGH_LEN);
  localparam int LOAD_LEN  = cyclesFor(LOAD_MINNS, SYS_MHZ);
  localparam int CNT_W     = $clog2(maxOf(maxOf(SETUP_LEN, HIGH_LEN),
                                          maxOf(LOW_LEN, LOAD_LEN)) + 1) + 1;

  loaderStbT stb;

  dacLoaderCtrl #(
    .WORD_BITS(WORD_BITS), .SETUP_LEN(SETUP_LEN), .HIGH_LEN(HIGH_LEN),
    .LOW_LEN(LOW_LEN), .LOAD_LEN(LOAD_LEN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .stb(stb), .busy(busy), .done(done)
  );

  dacLoaderPath #(.WORD_BITS(WORD_BITS)) u_path (
    .clk(clk), .rst(rst), .stb(stb), .code(code), .bipolar(bipolar),
    .sclk(sclk), .sdata(sdata), .ldN(ldN)
  );

  // load pulse lies inside the busy window (R8)
  p_load_inside_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !ldN |-> busy);

  // done follows a cycle where the load line was low (R8)
  p_done_after_load_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(!ldN) && ldN && !busy));

  // idle lines: clock low, load high (R9)
  p_idle_lines_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && ldN));

endmodule

// File: tb/dacWordLoader_test.sv
`timescale 1ns/1ps
module dacWordLoader_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [11:0] code = '0;
  logic        bipolar = 1'b0;
  logic        busy, done, sclk, sdata, ldN;

  int total = 0;
  int bad = 0;

  localparam int BUSY_CYC = 12 * (2 + 5 + 6) + 6;

  always #10 clk = ~clk;

  dacWordLoader uut (
    .clk(clk), .rst(rst), .start(start), .code(code), .bipolar(bipolar),
    .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .ldN(ldN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] expCode(input logic [11:0] c, input logic bip);
    return bip ? {~c[11], c[10:0]} : c;
  endfunction

  // receiver model
  logic [11:0] rxShift = '0;
  logic [11:0] dacReg = '0;
  int          edgeCnt = 0;
  realtime     tData = -1000.0, tRise = -1000.0, tFall = -1000.0, tLdFall = 0.0;

  always @(sdata) begin
    if (!rst && busy)
      check(($realtime - tRise) >= 80.0, "R5 hold", int'($realtime - tRise), 80);
    tData = $realtime;
  end

  always @(posedge sclk) begin
    check(($realtime - tData) >= 40.0, "R4 setup", int'($realtime - tData), 40);
    check(($realtime - tFall) >= 120.0, "R5 clock low", int'($realtime - tFall), 120);
    check(ldN, "R2 rise while load low", 0, 1);
    tRise = $realtime;
    rxShift = {rxShift[10:0], sdata};
    edgeCnt++;
  end

  always @(negedge sclk) begin
    if (!rst) check(($realtime - tRise) >= 90.0, "R5 clock high", int'($realtime - tRise), 90);
    tFall = $realtime;
  end

  always @(negedge ldN) begin
    check(edgeCnt == 12, "R2 edges before load", edgeCnt, 12);
    tLdFall = $realtime;
  end

  always @(posedge ldN) begin
    if (!rst) begin
      check(($realtime - tLdFall) >= 120.0, "R3 load width", int'($realtime - tLdFall), 120);
      dacReg = rxShift;
      edgeCnt = 0;
    end
  end

  // run one transfer; optionally fire a stray start mid-transfer
  task automatic transfer(input logic [11:0] c, input logic bip, input bit stray);
    logic [11:0] prevDac;
    int cyc;
    prevDac = dacReg;
    @(negedge clk);
    code = c; bipolar = bip; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    code = ~c; bipolar = ~bip;   // capture must have happened already (R7)
    check(busy, "R8 busy after accept", busy, 1);
    cyc = 1;
    while (busy && cyc < 400) begin
      @(negedge clk);
      if (cyc == 60) begin
        check(dacReg == prevDac, "R1 output held while shifting", dacReg, prevDac);
        if (stray) begin
          start = 1'b1; code = 12'h5A5; bipolar = 1'b1;
        end
      end
      if (cyc == 61) start = 1'b0;
      if (busy) cyc++;
    end
    check(cyc == BUSY_CYC, "R8 busy length", cyc, BUSY_CYC);
    check(done, "R8 done with busy low", done, 1);
    check(ldN && !sclk, "R3 lines idle after load", {ldN, sclk}, 2);
    check(dacReg == expCode(c, bip), stray ? "R7 stray start ignored" :
          (bip ? "R6 bipolar word" : "R1 word received"), dacReg, expCode(c, bip));
    @(negedge clk);
    check(!done && !busy, "R8 done one cycle", done, 0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done, "R9 reset handshake", {busy, done}, 0);
    check(!sclk && !sdata && ldN, "R9 reset lines", {sclk, sdata, ldN}, 1);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && ldN, "R9 idle after reset", {busy, ldN}, 1);

    transfer(12'hFFF, 1'b0, 1'b0);
    transfer(12'h000, 1'b0, 1'b0);
    transfer(12'h800, 1'b0, 1'b0);
    transfer(12'h001, 1'b0, 1'b0);
    transfer(12'h7FF, 1'b1, 1'b0);   // +2047 -> 0xFFF
    transfer(12'h800, 1'b1, 1'b0);   // -2048 -> 0x000
    transfer(12'hA5C, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      logic [11:0] rc;
      logic        rb;
      rc = 12'($urandom);
      rb = 1'($urandom);
      transfer(rc, rb, (i % 5) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule